// File: doc/BRIEF.md
# Two-Cycle Frequency Acquisition Sequencer

This block sets the starting control word of an all-digital PLL's oscillator before the tracking loop takes over. It starts from code zero, which gives the shortest oscillator period. After the first reference edge, it adds a fixed step to the control word on every divided-clock edge. At the second reference edge, it freezes the word. Acquisition takes two reference cycles in total.

From two time-to-digital readings it builds a straight-line model of the oscillator: period against control code. The first reading is the shortest divided period. The second is the period of the last divided cycle before the freeze. From that model it computes the code whose period matches the measured reference period. It then loads that code, raises a done flag for the coarse tracking stage, and watches the divided period against a pull-in window of half to twice the reference period.

All edge events are single-cycle pulses, synchronous to the system clock. A new acquisition needs a reset.

Top module: `freq_acq_seq`

## Requirements
- R1: After reset the control word is 0 and `done_o` and `oor_o` are 0. Divided-clock pulses that arrive before the first reference pulse leave the word at 0.
- R2: After the first reference pulse, every `div_edge_i` pulse adds `step_i` to the control word. The `tdc_i` value present with the first such pulse is kept as the shortest-period reading.
- R3: The second reference pulse freezes the word, and `tdc_cap_o` shows the `tdc_i` value from that cycle. A divided pulse that arrives in the same cycle as the second reference pulse is not added.
- R4: With frozen word W, shortest reading A, last reading B and reference reading R, where A < B, A ≤ R and W > 0, the loaded word is floor((2·W·(R−A) + (B−A)) / (2·(B−A))). This is W·(R−A)/(B−A) rounded half up.
- R5: `done_o` rises in the cycle the word is loaded and stays high. After that the word does not change, and further reference pulses have no effect.
- R6: Once done, a divided pulse with 2·`tdc_i` < R or `tdc_i` > 2·R sets `oor_o`. A pulse with values on or inside those bounds does not. `oor_o` stays set until reset.
- R7: If an addition during the ramp would pass the maximum code (2^WORD_W−1), the word saturates at the maximum and `oor_o` is set.
- R8: A computed word above the maximum loads the maximum. R < A loads 0. B ≤ A or W = 0 loads the maximum. Each of these cases also sets `oor_o`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | System clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| ref_edge_i | input | 1 | One-cycle pulse per reference clock edge |
| div_edge_i | input | 1 | One-cycle pulse per divided output clock edge |
| tdc_i | input | TDC_W | Divided-period reading in TDC counts, valid with a pulse |
| ref_tdc_i | input | TDC_W | Reference period in TDC counts, sampled at the second reference pulse |
| step_i | input | WORD_W | Ramp step added per divided edge |
| ctrl_word_o | output | WORD_W | Oscillator control word |
| tdc_cap_o | output | TDC_W | Reading captured at the second reference pulse |
| done_o | output | 1 | Acquisition complete; hand over to coarse tracking |
| oor_o | output | 1 | Sticky out-of-range and saturation flag |

## Verification
Two events can fall in the same cycle: the freeze caused by the second reference edge, and a ramp step caused by a divided edge. The bench drives both pulses in one cycle. It then expects the word to keep the value reached after the earlier steps only, and checks that the loaded word is computed from that value. A second overlap occurs when saturation and the freeze meet: the vectors include a ramp that overflows, and the bench judges that the loaded word is computed from the saturated code with the flag set.

// File: rtl/freq_acq_pkg.sv
package freq_acq_pkg;
  typedef enum logic [1:0] {ST_IDLE, ST_RAMP, ST_CALC, ST_DONE} acq_state_e;
endpackage

// File: rtl/freq_acq_ramp.sv
module freq_acq_ramp #(
  parameter int WORD_W = 12
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              add_i,
  input  logic [WORD_W-1:0] step_i,
  input  logic              load_i,
  input  logic [WORD_W-1:0] load_val_i,
  output logic [WORD_W-1:0] word_o,
  output logic              sat_o
);
  logic [WORD_W:0] sum;
  assign sum = {1'b0, word_o} + {1'b0, step_i};

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      word_o <= '0;
      sat_o  <= 1'b0;
    end else if (load_i) begin
      word_o <= load_val_i;
    end else if (add_i) begin
      if (sum[WORD_W]) begin
        word_o <= '1;
        sat_o  <= 1'b1;
      end else begin
        word_o <= sum[WORD_W-1:0];
      end
    end
  end
endmodule

// File: rtl/freq_acq_div.sv
module freq_acq_div #(
  parameter int NUM_W = 24,
  parameter int DEN_W = 12
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             start_i,
  input  logic [NUM_W-1:0] num_i,
  input  logic [DEN_W-1:0] den_i,
  output logic             done_o,
  output logic [NUM_W-1:0] quo_o
);
  localparam int CNT_W = $clog2(NUM_W + 1);

  logic [DEN_W-1:0] rem_q, den_q;
  logic [CNT_W-1:0] cnt_q;
  logic             busy_q;
  logic [DEN_W:0]   shifted, diff;
  logic             ge;

  assign shifted = {rem_q, quo_o[NUM_W-1]};
  assign diff    = shifted - {1'b0, den_q};
  assign ge      = shifted >= {1'b0, den_q};

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      rem_q  <= '0;
      den_q  <= '0;
      quo_o  <= '0;
      cnt_q  <= '0;
      busy_q <= 1'b0;
      done_o <= 1'b0;
    end else begin
      done_o <= 1'b0;
      if (start_i) begin
        rem_q  <= '0;
        den_q  <= den_i;
        quo_o  <= num_i;
        cnt_q  <= CNT_W'(NUM_W);
        busy_q <= 1'b1;
      end else if (busy_q) begin
        rem_q <= ge ? diff[DEN_W-1:0] : shifted[DEN_W-1:0];
        quo_o <= {quo_o[NUM_W-2:0], ge};
        cnt_q <= cnt_q - 1'b1;
        if (cnt_q == CNT_W'(1)) begin
          busy_q <= 1'b0;
          done_o <= 1'b1;
        end
      end
    end
  end
endmodule

// File: rtl/freq_acq_seq.sv
module freq_acq_seq
  import freq_acq_pkg::*;
#(
  parameter int WORD_W = 12,
  parameter int TDC_W  = 10
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              ref_edge_i,
  input  logic              div_edge_i,
  input  logic [TDC_W-1:0]  tdc_i,
  input  logic [TDC_W-1:0]  ref_tdc_i,
  input  logic [WORD_W-1:0] step_i,
  output logic [WORD_W-1:0] ctrl_word_o,
  output logic [TDC_W-1:0]  tdc_cap_o,
  output logic              done_o,
  output logic              oor_o
);
  localparam int NUM_W = WORD_W + TDC_W + 2;
  localparam int DEN_W = TDC_W + 2;
  localparam logic [WORD_W-1:0] WORD_MAX = '1;

  acq_state_e state_q, state_d;
  logic [TDC_W-1:0] tmin_q, ref_q;
  logic             first_div_q, calc_start_q, oor_q;
  logic             add, load, set_oor, div_start, div_done, sat;
  logic [WORD_W-1:0] load_val;
  logic [TDC_W-1:0] span, offs;
  logic [NUM_W-1:0] num, quo;
  logic [DEN_W-1:0] den2;
  logic             degenerate, below, quo_ovf;

  // linear model: word = W*(R-A)/(B-A), rounded half up via 2x scaling
  assign span       = tdc_cap_o - tmin_q;
  assign offs       = ref_q - tmin_q;
  assign num        = NUM_W'(ctrl_word_o) * NUM_W'(offs) * NUM_W'(2) + NUM_W'(span);
  assign den2       = DEN_W'({span, 1'b0});
  assign degenerate = (ctrl_word_o == '0) || (tdc_cap_o <= tmin_q);
  assign below      = ref_q < tmin_q;
  assign quo_ovf    = |quo[NUM_W-1:WORD_W];

  assign add = (state_q == ST_RAMP) && div_edge_i && !ref_edge_i;

  always_comb begin
    state_d   = state_q;
    load      = 1'b0;
    load_val  = '0;
    set_oor   = 1'b0;
    div_start = 1'b0;
    unique case (state_q)
      ST_IDLE: if (ref_edge_i) state_d = ST_RAMP;
      ST_RAMP: if (ref_edge_i) state_d = ST_CALC;
      ST_CALC: begin
        if (calc_start_q) begin
          if (degenerate) begin
            load = 1'b1; load_val = WORD_MAX; set_oor = 1'b1; state_d = ST_DONE;
          end else if (below) begin
            load = 1'b1; load_val = '0; set_oor = 1'b1; state_d = ST_DONE;
          end else begin
            div_start = 1'b1;
          end
        end else if (div_done) begin
          load     = 1'b1;
          load_val = quo_ovf ? WORD_MAX : quo[WORD_W-1:0];
          set_oor  = quo_ovf;
          state_d  = ST_DONE;
        end
      end
      ST_DONE: begin
        if (div_edge_i && (({tdc_i, 1'b0} < {1'b0, ref_q}) ||
                           ({1'b0, tdc_i} > {ref_q, 1'b0})))
          set_oor = 1'b1;
      end
      default: state_d = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q      <= ST_IDLE;
      tmin_q       <= '0;
      tdc_cap_o    <= '0;
      ref_q        <= '0;
      first_div_q  <= 1'b0;
      calc_start_q <= 1'b0;
      oor_q        <= 1'b0;
    end else begin
      state_q      <= state_d;
      calc_start_q <= (state_q == ST_RAMP) && ref_edge_i;
      oor_q        <= oor_q | set_oor;
      if (state_q == ST_IDLE && ref_edge_i) first_div_q <= 1'b1;
      if (add && first_div_q) begin
        tmin_q      <= tdc_i;
        first_div_q <= 1'b0;
      end
      if (state_q == ST_RAMP && ref_edge_i) begin
        tdc_cap_o <= tdc_i;
        ref_q     <= ref_tdc_i;
      end
    end
  end

  freq_acq_ramp #(.WORD_W(WORD_W)) u_ramp (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .add_i      (add),
    .step_i     (step_i),
    .load_i     (load),
    .load_val_i (load_val),
    .word_o     (ctrl_word_o),
    .sat_o      (sat)
  );

  freq_acq_div #(.NUM_W(NUM_W), .DEN_W(DEN_W)) u_div (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .start_i (div_start),
    .num_i   (num),
    .den_i   (den2),
    .done_o  (div_done),
    .quo_o   (quo)
  );

  assign done_o = (state_q == ST_DONE);
  assign oor_o  = oor_q | sat;
endmodule

// File: rtl/freq_acq_seq_chk.sv
module freq_acq_seq_chk
  import freq_acq_pkg::*;
#(
  parameter int WORD_W = 12
) (
  input logic              clk_i,
  input logic              rst_ni,
  input acq_state_e        state_i,
  input logic [WORD_W-1:0] word_i,
  input logic [WORD_W-1:0] step_i,
  input logic              ref_edge_i,
  input logic              div_edge_i,
  input logic              done_i,
  input logic              oor_i
);
  localparam logic [WORD_W-1:0] WMAX = '1;

  AST_IDLE_ZERO: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (state_i == ST_IDLE) |-> (word_i == '0)); // R1

  AST_RAMP_STEP: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (state_i == ST_RAMP && div_edge_i && !ref_edge_i &&
     ({1'b0, word_i} + {1'b0, step_i} <= {1'b0, WMAX}))
    |=> (word_i == $past(word_i) + $past(step_i))); // R2

  AST_CALC_HOLD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (state_i == ST_CALC) |=> ($stable(word_i) || state_i == ST_DONE)); // R3

  AST_DONE_HOLD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_i |=> (done_i && $stable(word_i))); // R5

  AST_OOR_STICKY: assert property (@(posedge clk_i) disable iff (!rst_ni)
    oor_i |=> oor_i); // R6

  AST_RAMP_SAT: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (state_i == ST_RAMP && div_edge_i && !ref_edge_i &&
     ({1'b0, word_i} + {1'b0, step_i} > {1'b0, WMAX}))
    |=> (oor_i && word_i == WMAX)); // R7
endmodule

bind freq_acq_seq freq_acq_seq_chk #(.WORD_W(WORD_W)) u_chk (
  .clk_i      (clk_i),
  .rst_ni     (rst_ni),
  .state_i    (state_q),
  .word_i     (ctrl_word_o),
  .step_i     (step_i),
  .ref_edge_i (ref_edge_i),
  .div_edge_i (div_edge_i),
  .done_i     (done_o),
  .oor_i      (oor_o)
);

// File: tb/freq_acq_seq_bench.sv
`timescale 1ns/1ps
module freq_acq_seq_bench;
  localparam int WORD_W = 12;
  localparam int TDC_W  = 10;
  localparam int WMAX   = (1 << WORD_W) - 1;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic ref_edge = 1'b0, div_edge = 1'b0;
  logic [TDC_W-1:0]  tdc = '0, ref_tdc = '0;
  logic [WORD_W-1:0] step = '0;
  logic [WORD_W-1:0] word;
  logic [TDC_W-1:0]  tdc_cap;
  logic done, oor;

  int n_run = 0, n_fail = 0;
  bit finished = 0;

  always #5 clk = ~clk;

  freq_acq_seq #(.WORD_W(WORD_W), .TDC_W(TDC_W)) u_freq_acq_seq (
    .clk_i(clk), .rst_ni(rst_n), .ref_edge_i(ref_edge), .div_edge_i(div_edge),
    .tdc_i(tdc), .ref_tdc_i(ref_tdc), .step_i(step),
    .ctrl_word_o(word), .tdc_cap_o(tdc_cap), .done_o(done), .oor_o(oor));

  // {step, div edges, shortest reading, last reading, reference}
  localparam int NV = 7;
  localparam int VEC [NV][5] = '{
    '{16,   8, 100, 164, 132},
    '{20,  10,  50, 250, 120},
    '{3,    5,  10,  17,  14},
    '{100, 10, 100, 110, 200},
    '{1000, 5, 100, 300, 200},
    '{10,   4, 200, 240, 150},
    '{10,   4, 200, 200, 300}
  };

  task automatic check(input int act, input int exp, input string req);
    n_run++;
    if (act != exp) begin
      n_fail++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  task automatic pulse(input bit r, input bit d, input int t, input int rp);
    @(negedge clk);
    ref_edge = r; div_edge = d; tdc = TDC_W'(t); ref_tdc = TDC_W'(rp);
    @(negedge clk);
    ref_edge = 0; div_edge = 0;
  endtask

  task automatic do_reset();
    @(negedge clk); rst_n = 0;
    @(negedge clk); rst_n = 1;
  endtask

  function automatic int expect_word(input int p, input int n, input int a,
                                     input int b, input int r, output bit ov);
    int w, q;
    w = p * n; ov = 0;
    if (w > WMAX) begin w = WMAX; ov = 1; end
    if (w == 0 || b <= a) begin ov = 1; return WMAX; end
    if (r < a) begin ov = 1; return 0; end
    q = (2 * w * (r - a) + (b - a)) / (2 * (b - a));
    if (q > WMAX) begin ov = 1; q = WMAX; end
    return q;
  endfunction

  // full acquisition; coin=1 places one divided pulse with the freeze
  task automatic run_acq(input int p, input int n, input int a, input int b,
                         input int r, input bit coin);
    int wexp, fexp, waited;
    bit ovexp;
    do_reset();
    step = WORD_W'(p);
    pulse(1, 0, 0, 0);
    for (int k = 0; k < n; k++) pulse(0, 1, (k == 0) ? a : 999, 0);
    fexp = (p * n > WMAX) ? WMAX : p * n;
    check(int'(word), fexp, "R2 ramp word");
    if (p * n > WMAX) check(int'(oor), 1, "R7 ramp saturation flag");
    pulse(1, coin, b, r);
    check(int'(word), fexp, "R3 frozen word");
    check(int'(tdc_cap), b, "R3 captured reading");
    waited = 0;
    while (!done && waited < 200) begin @(negedge clk); waited++; end
    wexp = expect_word(p, n, a, b, r, ovexp);
    check(int'(done), 1, "R5 done raised");
    check(int'(word), wexp, "R4/R8 loaded word");
    check(int'(oor), int'(ovexp), "R7/R8 range flag");
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!finished) begin
      n_fail++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
      $finish;
    end
  end

  initial begin
    // R1 reset state and ignored pre-start edges
    do_reset();
    check(int'(word), 0, "R1 reset word");
    check(int'(done), 0, "R1 reset done");
    check(int'(oor), 0, "R1 reset flag");
    step = 12'd7;
    for (int k = 0; k < 3; k++) pulse(0, 1, 50, 0);
    check(int'(word), 0, "R1 idle divided edges ignored");

    for (int v = 0; v < NV; v++)
      run_acq(VEC[v][0], VEC[v][1], VEC[v][2], VEC[v][3], VEC[v][4], 0);

    // R3 coincident freeze and step: word 10, result 5, ref reading 20
    run_acq(5, 2, 10, 30, 20, 1);
    pulse(0, 1, 10, 0);
    check(int'(oor), 0, "R6 low bound inside");
    pulse(0, 1, 40, 0);
    check(int'(oor), 0, "R6 high bound inside");
    pulse(0, 1, 41, 0);
    check(int'(oor), 1, "R6 above twice reference");
    pulse(1, 0, 0, 0);
    check(int'(word), 5, "R5 word held after late reference edge");
    check(int'(done), 1, "R5 done held");
    pulse(0, 1, 20, 0);
    check(int'(oor), 1, "R6 flag sticky");

    run_acq(5, 2, 10, 30, 20, 0);
    pulse(0, 1, 9, 0);
    check(int'(oor), 1, "R6 below half reference");

    finished = 1;
    $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end
endmodule